// File: doc/BRIEF.md
# Indexed Display-Controller Register Port File

This block holds the CPU-visible control registers of a VGA-style display controller. They sit in four indexed banks: CRT, attribute, sequencer and graphics. Software reaches them through byte-wide I/O ports on a synchronous bus. The CRT, sequencer and graphics banks each pair an index port with a data port. The attribute bank has one write port whose role flips between index and data on every write. A read of the input-status port returns that flip-flop to the index role. A separate attribute read port returns the selected register.

The block also converts CPU writes to the two cursor-location bytes of the CRT bank into a text row and column. It forms the linear position `row * cols + col`, replaces one byte of it, and then divides by the configured column count. A restoring divider does the division over sixteen cycles. While it runs, `cur_busy` is high.

Top module: `vreg_portfile`

## Requirements
- R1: A write to an index port (0x3D4 CRT, 0x3C4 sequencer, 0x3CE graphics) latches the byte as that bank's index. A read of the same port returns the latched index.
- R2: A write to a data port (0x3D5, 0x3C5, 0x3CF) stores the byte in the register at the bank's current index, and a read returns that register. `rdata` carries the read value in the cycle after `rd_en` and is 0x00 in every cycle that does not follow a read.
- R3: After reset, the first write to the attribute write port 0x3C0 is taken as an index. The next write is taken as data, and the roles alternate on every later write.
- R4: A read of the input-status port 0x3DA returns `stat_in` and puts the attribute flip-flop into the index role. This also holds if a write to 0x3C0 happens in the same cycle.
- R5: A read of 0x3C1 returns the attribute register selected by the last attribute index written.
- R6: The banks hold 25 (CRT), 21 (attribute), 5 (sequencer) and 9 (graphics) registers. An index at or beyond a bank's size reads 0x00, and data written at that index changes no register.
- R7: Reads of any other address, including 0x3C0, return 0x00. Writes to the monochrome CRT ports 0x3B4 and 0x3B5 change nothing.
- R8: After reset, sequencer register 0 holds 0x03. Every other register and every index hold 0x00, the attribute flip-flop is in the index role, row and column are 0, and `cur_busy` is low.
- R9: A CRT data write at index 0x0E replaces bits 15:8 of the position `row * cols + col`, and one at index 0x0F replaces bits 7:0. `cur_busy` rises in the next cycle. When it falls, `cur_row` equals the new position divided by `cols` and `cur_col` equals the remainder.
- R10: A CRT data write at index 0x0E or 0x0F while `cur_busy` is high is ignored. Neither the CRT register nor the cursor position changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write byte |
| stat_in | input | 8 | Byte returned by the input-status port |
| cols | input | 8 | Text columns per row, must be nonzero |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| cur_row | output | 16 | Cursor row |
| cur_col | output | 8 | Cursor column |
| cur_busy | output | 1 | Cursor conversion in progress |

## Verification
If the attribute flip-flop is in the wrong state, index and data swap. The fault shows on the next read of 0x3C1, which returns a register the software never selected or a byte from the wrong write. A stale bank index appears on the very next index-port or data-port read, one cycle after the strobe. A fault in the cursor arithmetic stays hidden until `cur_busy` falls, about sixteen cycles after the write, and then appears as a row or column that disagrees with the integer quotient and remainder. A broken busy guard shows as a changed cursor register or a shifted position after a write that should have been ignored.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  localparam int NBANK = 4;
  localparam int BK_CRT  = 0;
  localparam int BK_ATTR = 1;
  localparam int BK_SEQ  = 2;
  localparam int BK_GFX  = 3;
  localparam int POS_W   = 16;

  localparam logic [15:0] P_CRT_IDX  = 16'h03D4;
  localparam logic [15:0] P_CRT_DAT  = 16'h03D5;
  localparam logic [15:0] P_MONO_IDX = 16'h03B4;
  localparam logic [15:0] P_MONO_DAT = 16'h03B5;
  localparam logic [15:0] P_ATTR_WR  = 16'h03C0;
  localparam logic [15:0] P_ATTR_RD  = 16'h03C1;
  localparam logic [15:0] P_SEQ_IDX  = 16'h03C4;
  localparam logic [15:0] P_SEQ_DAT  = 16'h03C5;
  localparam logic [15:0] P_GFX_IDX  = 16'h03CE;
  localparam logic [15:0] P_GFX_DAT  = 16'h03CF;
  localparam logic [15:0] P_STAT    = 16'h03DA;

  localparam logic [7:0] CUR_HI_IDX = 8'h0E;
  localparam logic [7:0] CUR_LO_IDX = 8'h0F;

  function automatic int bank_depth(input int b);
    case (b)
      BK_CRT:  return 25;
      BK_ATTR: return 21;
      BK_SEQ:  return 5;
      default: return 9;
    endcase
  endfunction

  function automatic logic [7:0] bank_rst0(input int b);
    return (b == BK_SEQ) ? 8'h03 : 8'h00;
  endfunction

  function automatic logic [15:0] bank_idx_port(input int b);
    case (b)
      BK_CRT:  return P_CRT_IDX;
      BK_ATTR: return P_ATTR_WR;
      BK_SEQ:  return P_SEQ_IDX;
      default: return P_GFX_IDX;
    endcase
  endfunction

  function automatic logic [15:0] bank_dat_port(input int b);
    case (b)
      BK_CRT:  return P_CRT_DAT;
      BK_ATTR: return P_ATTR_WR;
      BK_SEQ:  return P_SEQ_DAT;
      default: return P_GFX_DAT;
    endcase
  endfunction
endpackage

// File: rtl/vreg_bank.sv
module vreg_bank #(
  parameter int         DEPTH = 8,
  parameter logic [7:0] RST0  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic [7:0] idx_wd,
  input  logic       dat_we,
  input  logic [7:0] dat_wd,
  output logic [7:0] idx_q,
  output logic [7:0] dat_q
);
  localparam logic [7:0] DEPTH_V = 8'(DEPTH);

  logic [7:0] regs [DEPTH];
  logic       idx_in;

  assign idx_in = (idx_q < DEPTH_V);

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 8'h00;
    else if (idx_we) idx_q <= idx_wd;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) regs[i] <= (i == 0) ? RST0 : 8'h00;
      else if (dat_we && idx_q == 8'(i)) regs[i] <= dat_wd;
    end
  end

  always_comb begin
    dat_q = 8'h00;
    for (int i = 0; i < DEPTH; i++)
      if (idx_q == 8'(i)) dat_q = regs[i];
  end

  assert_wr_then_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_in && !idx_we) |=> (dat_q == $past(dat_wd)));

  assert_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_in |-> (dat_q == 8'h00));
endmodule

// File: rtl/vreg_attr_flop.sv
module vreg_attr_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic clr,
  output logic tog_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)      tog_data <= 1'b0;
    else if (clr)    tog_data <= 1'b0;
    else if (wr_hit) tog_data <= ~tog_data;
  end

  assert_tog_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !clr) |=> (tog_data != $past(tog_data)));

  assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tog_data);
endmodule

// File: rtl/vreg_cursor.sv
module vreg_cursor #(
  parameter int POS_W = 16,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [POS_W-1:0] start_pos,
  input  logic [COL_W-1:0] cols,
  output logic             busy,
  output logic [POS_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam int CW = $clog2(POS_W + 1);
  localparam int RW = COL_W + 1;
  localparam logic [CW-1:0] LAST = CW'(POS_W - 1);

  logic [RW-1:0]    rem;
  logic [POS_W-1:0] quo;
  logic [COL_W-1:0] div_l;
  logic [CW-1:0]    cnt;
  logic [RW+POS_W-1:0] nxt;

  function automatic logic [RW+POS_W-1:0] div_step(
    input logic [RW-1:0] r, input logic [POS_W-1:0] q, input logic [COL_W-1:0] d);
    logic [RW:0]   trial;
    logic [RW-1:0] r_n;
    logic          bit_n;
    trial = {r, q[POS_W-1]};
    if (trial >= {2'b00, d}) begin
      trial = trial - {2'b00, d};
      bit_n = 1'b1;
    end else begin
      bit_n = 1'b0;
    end
    r_n = trial[RW-1:0];
    return {r_n, q[POS_W-2:0], bit_n};
  endfunction

  assign nxt = div_step(rem, quo, div_l);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rem   <= '0;
      quo   <= '0;
      div_l <= COL_W'(1);
      cnt   <= '0;
      row   <= '0;
      col   <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      rem   <= '0;
      quo   <= start_pos;
      div_l <= cols;
      cnt   <= '0;
    end else if (busy) begin
      rem <= nxt[RW+POS_W-1:POS_W];
      quo <= nxt[POS_W-1:0];
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        busy <= 1'b0;
        row  <= nxt[POS_W-1:0];
        col  <= nxt[POS_W+COL_W-1:POS_W];
      end
    end
  end

  assert_col_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (col < div_l));

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/vreg_portfile.sv
module vreg_portfile
  import vreg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  input  logic [7:0]       stat_in,
  input  logic [COL_W-1:0] cols,
  output logic [7:0]       rdata,
  output logic [POS_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             cur_busy
);
  localparam int WW = POS_W + COL_W + 1;

  logic [7:0] bk_idx [NBANK];
  logic [7:0] bk_dat [NBANK];
  logic       attr_tog;
  logic       attr_hit;
  logic       stat_rd;
  logic       cur_hit;
  logic       cur_block;
  logic       cur_start;
  logic [POS_W-1:0] pos_now;
  logic [POS_W-1:0] pos_new;
  logic [7:0] rd_mux;

  function automatic logic [POS_W-1:0] cur_linear(
    input logic [POS_W-1:0] r, input logic [COL_W-1:0] c, input logic [COL_W-1:0] n);
    logic [WW-1:0] w;
    w = WW'(r) * WW'(n) + WW'(c);
    return w[POS_W-1:0];
  endfunction

  function automatic logic [POS_W-1:0] cur_merge(
    input logic [POS_W-1:0] p, input logic hi, input logic [7:0] b);
    return hi ? {b, p[7:0]} : {p[POS_W-1:8], b};
  endfunction

  assign attr_hit = wr_en && (addr == P_ATTR_WR);
  assign stat_rd  = rd_en && (addr == P_STAT);
  assign cur_hit  = wr_en && (addr == P_CRT_DAT) &&
                    ((bk_idx[BK_CRT] == CUR_HI_IDX) || (bk_idx[BK_CRT] == CUR_LO_IDX));
  assign cur_block = cur_hit && cur_busy;
  assign cur_start = cur_hit && !cur_busy;
  assign pos_now   = cur_linear(cur_row, cur_col, cols);
  assign pos_new   = cur_merge(pos_now, bk_idx[BK_CRT] == CUR_HI_IDX, wdata);

  vreg_attr_flop u_attr_flop (
    .clk(clk), .rst_n(rst_n), .wr_hit(attr_hit), .clr(stat_rd), .tog_data(attr_tog)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic iw;
    logic dw;
    if (b == BK_ATTR) begin : g_attr
      assign iw = attr_hit && !attr_tog;
      assign dw = attr_hit && attr_tog;
    end else if (b == BK_CRT) begin : g_crt
      assign iw = wr_en && (addr == bank_idx_port(b));
      assign dw = wr_en && (addr == bank_dat_port(b)) && !cur_block;
    end else begin : g_plain
      assign iw = wr_en && (addr == bank_idx_port(b));
      assign dw = wr_en && (addr == bank_dat_port(b));
    end

    vreg_bank #(.DEPTH(bank_depth(b)), .RST0(bank_rst0(b))) u_bank (
      .clk(clk), .rst_n(rst_n),
      .idx_we(iw), .idx_wd(wdata),
      .dat_we(dw), .dat_wd(wdata),
      .idx_q(bk_idx[b]), .dat_q(bk_dat[b])
    );
  end

  vreg_cursor #(.POS_W(POS_W), .COL_W(COL_W)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .start(cur_start), .start_pos(pos_new), .cols(cols),
    .busy(cur_busy), .row(cur_row), .col(cur_col)
  );

  always_comb begin
    case (addr)
      P_CRT_IDX: rd_mux = bk_idx[BK_CRT];
      P_CRT_DAT: rd_mux = bk_dat[BK_CRT];
      P_ATTR_RD: rd_mux = bk_dat[BK_ATTR];
      P_SEQ_IDX: rd_mux = bk_idx[BK_SEQ];
      P_SEQ_DAT: rd_mux = bk_dat[BK_SEQ];
      P_GFX_IDX: rd_mux = bk_idx[BK_GFX];
      P_GFX_DAT: rd_mux = bk_dat[BK_GFX];
      P_STAT:    rd_mux = stat_in;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= 8'h00;
  end

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (rdata == 8'h00));

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_start |=> cur_busy);
endmodule

// File: tb/vreg_portfile_tb_top.sv
`timescale 1ns/1ps
module vreg_portfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = 8'h0;
  logic [7:0]  stat_in = 8'h09;
  logic [7:0]  cols = 8'd80;
  logic [7:0]  rdata;
  logic [15:0] cur_row;
  logic [7:0]  cur_col;
  logic        cur_busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int m_row = 0;
  int m_col = 0;

  vreg_portfile dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .stat_in(stat_in), .cols(cols), .rdata(rdata),
    .cur_row(cur_row), .cur_col(cur_col), .cur_busy(cur_busy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 16'h0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; addr = 16'h0;
    d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 64; i++) begin
      if (!cur_busy) break;
      @(negedge clk);
    end
  endtask

  task automatic model_cur(input bit hi, input int b);
    int p;
    p = (m_row * cols + m_col) & 16'hFFFF;
    p = hi ? ((b << 8) | (p & 8'hFF)) : ((p & 16'hFF00) | b);
    m_row = p / cols;
    m_col = p % cols;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R8 rdata", rdata, 0);
    check("R8 row", cur_row, 0);
    check("R8 col", cur_col, 0);
    check("R8 busy", cur_busy, 0);
    io_rd(16'h03C5, d); check("R8 seq reg0", d, 8'h03);
    io_rd(16'h03D4, d); check("R8 crt index", d, 0);
    io_rd(16'h03D5, d); check("R8 crt reg0", d, 0);
    @(negedge clk); check("R2 rdata idle", rdata, 0);
  endtask

  task automatic t_index_data();
    logic [7:0] d;
    io_wr(16'h03D4, 8'h0A); io_rd(16'h03D4, d); check("R1 crt index", d, 8'h0A);
    io_wr(16'h03D5, 8'h5C); io_rd(16'h03D5, d); check("R2 crt data", d, 8'h5C);
    io_wr(16'h03CE, 8'h08); io_rd(16'h03CE, d); check("R1 gfx index", d, 8'h08);
    io_wr(16'h03CF, 8'hE7); io_rd(16'h03CF, d); check("R2 gfx data", d, 8'hE7);
    io_wr(16'h03C4, 8'h02); io_wr(16'h03C5, 8'h0F);
    io_rd(16'h03C4, d); check("R1 seq index", d, 8'h02);
    io_rd(16'h03C5, d); check("R2 seq data", d, 8'h0F);
    io_wr(16'h03C4, 8'h00); io_rd(16'h03C5, d); check("R2 seq reg0 kept", d, 8'h03);
  endtask

  task automatic t_attr();
    logic [7:0] d;
    io_wr(16'h03C0, 8'h05); io_wr(16'h03C0, 8'h3A);
    io_rd(16'h03C1, d); check("R3 R5 attr first pair", d, 8'h3A);
    io_wr(16'h03C0, 8'h06); io_wr(16'h03C0, 8'h11);
    io_rd(16'h03C1, d); check("R3 attr second pair", d, 8'h11);
    io_wr(16'h03C0, 8'h02);
    io_rd(16'h03DA, d); check("R4 status byte", d, 8'h09);
    io_wr(16'h03C0, 8'h05);
    io_rd(16'h03C1, d); check("R4 write after status is index", d, 8'h3A);
    io_wr(16'h03C0, 8'h77);
    io_rd(16'h03C1, d); check("R3 data after index", d, 8'h77);
    io_rd(16'h03C0, d); check("R7 attr write port reads zero", d, 0);
  endtask

  task automatic t_oob();
    logic [7:0] d;
    io_wr(16'h03C4, 8'h05); io_wr(16'h03C5, 8'hAA);
    io_rd(16'h03C5, d); check("R6 seq index 5 reads zero", d, 0);
    io_wr(16'h03C4, 8'h00); io_rd(16'h03C5, d); check("R6 seq reg0 untouched", d, 8'h03);
    io_wr(16'h03C0, 8'd21); io_wr(16'h03C0, 8'h99);
    io_rd(16'h03C1, d); check("R6 attr index 21 reads zero", d, 0);
    io_wr(16'h03D4, 8'd24); io_wr(16'h03D5, 8'h42);
    io_rd(16'h03D5, d); check("R6 crt last register", d, 8'h42);
  endtask

  task automatic t_mono();
    logic [7:0] d;
    io_wr(16'h03D4, 8'h0A);
    io_wr(16'h03B4, 8'h01); io_wr(16'h03B5, 8'h55);
    io_rd(16'h03D4, d); check("R7 mono index ignored", d, 8'h0A);
    io_rd(16'h03D5, d); check("R7 mono data ignored", d, 8'h5C);
    io_rd(16'h03B5, d); check("R7 mono read zero", d, 0);
    io_rd(16'h0300, d); check("R7 unmapped read zero", d, 0);
  endtask

  task automatic t_cursor();
    logic [7:0] d;
    io_wr(16'h03D4, 8'h0E); io_wr(16'h03D5, 8'h07);
    check("R9 busy after hi write", cur_busy, 1);
    model_cur(1'b1, 8'h07); wait_idle();
    check("R9 row after hi", cur_row, m_row); check("R9 col after hi", cur_col, m_col);
    io_wr(16'h03D4, 8'h0F); io_wr(16'h03D5, 8'h9F);
    model_cur(1'b0, 8'h9F); wait_idle();
    check("R9 row after lo", cur_row, m_row); check("R9 col after lo", cur_col, m_col);
    check("R9 expected row 24", m_row, 24);
    io_wr(16'h03D4, 8'h0E); io_wr(16'h03D5, 8'h02);
    model_cur(1'b1, 8'h02);
    @(negedge clk); addr = 16'h03D4; wdata = 8'h0F; wr_en = 1'b1;
    @(negedge clk); addr = 16'h03D5; wdata = 8'h11;
    @(negedge clk); wr_en = 1'b0; addr = 16'h0;
    wait_idle();
    check("R10 row ignores busy write", cur_row, m_row);
    check("R10 col ignores busy write", cur_col, m_col);
    io_rd(16'h03D5, d); check("R10 lo register unchanged", d, 8'h9F);
    cols = 8'd40;
    io_wr(16'h03D5, 8'h00);
    model_cur(1'b0, 8'h00); wait_idle();
    check("R9 row with 40 columns", cur_row, m_row);
    check("R9 col with 40 columns", cur_col, m_col);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index_data();
    t_attr();
    t_oob();
    t_mono();
    t_cursor();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule